// File: doc/BRIEF.md
# External Interrupt Context Register with Preemption Threshold Stack

This block is the 32-bit machine-mode context register that a core consults while it dispatches nested external interrupts. It keeps the number of the interrupt being serviced, a "not in an interrupt" marker, and a three-deep stack of preemption thresholds. The top of the stack is the minimum priority that may preempt the running handler. The second entry hides interrupts that a preempted frame may still be servicing. The third entry only carries values down the stack so that nesting of any depth unwinds correctly once software saves and restores the register.

The trap unit drives the stack. Entry to the external interrupt vector pushes the thresholds and arms a return flag. A return-from-trap pops them, but only while that flag is armed. Any other trap disarms the flag. When software requests an update, the top threshold and the interrupt identity load from the priority selector. The block also gives software a one-write way to mask the timer and software interrupt enables while keeping copies of them. A later write can put those enables back by setting them again.

Top module: `intctx_reg`

## Requirements
- R1: Read layout: bits 31:28 third threshold, 27:24 second threshold, 20:16 top threshold, 15 idle marker, 12:4 interrupt number, 3 timer-enable copy, 2 software-enable copy, 0 return flag. Bits 23:21, 14:13 and 1 read as zero. After reset every field is zero except the idle marker, so the register reads 0x0000_8000.
- R2: On external-vector entry, the third threshold takes the second, the second takes the top, and the return flag is set. The top threshold, number and marker do not change.
- R3: On return-from-trap with the flag set, the top threshold takes the zero-extended second, the second takes the third, the third becomes 0, and the flag clears.
- R4: Return-from-trap with the flag clear changes nothing.
- R5: Any other trap clears the return flag and leaves every other field unchanged.
- R6: On the update strobe, the top threshold becomes the larger of (selected priority + 1) and the second threshold. The number and idle marker load the selector's values.
- R7: A CSR write loads the three thresholds, the number, the idle marker and the flag from the same bit positions used for reading.
- R8: A write with bit 1 set pulses `en_clr_o` in that cycle and stores the current timer and software enables. Bits 3 and 2 then read back those stored copies until a write with bit 1 clear. In every other state they read 0.
- R9: A write with bit 1 clear pulses `tie_set_o` and `sie_set_o` from bits 3 and 2 in that cycle. When bit 1 is set, no set pulse is issued.
- R10: Only one event acts per cycle, taken in this order: entry, return-from-trap, other trap, update, CSR write. Every lower event in that cycle is dropped.
- R11: `thr_o` and `thr_prev_o` always equal the top and second thresholds.
- R12: Pushing a top threshold of 16 stores 15 in the 4-bit second entry.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| ext_entry_i | input | 1 | Core enters the external interrupt vector |
| other_trap_i | input | 1 | Core takes any other trap |
| mret_i | input | 1 | Return-from-trap retires |
| csr_wen_i | input | 1 | CSR write strobe |
| csr_wdata_i | input | 32 | CSR write data |
| csr_rdata_o | output | 32 | CSR read data |
| upd_i | input | 1 | Load context from the selector |
| sel_prio_i | input | 4 | Priority of the selected interrupt |
| sel_irq_i | input | 9 | Index of the selected interrupt |
| sel_none_i | input | 1 | Selector found no eligible interrupt |
| mtie_i | input | 1 | Live timer interrupt enable |
| msie_i | input | 1 | Live software interrupt enable |
| en_clr_o | output | 1 | Clear timer and software enables |
| tie_set_o | output | 1 | Set timer enable |
| sie_set_o | output | 1 | Set software enable |
| thr_o | output | 5 | Top preemption threshold |
| thr_prev_o | output | 4 | Second preemption threshold |

## Verification
The collision of most interest is an external-vector entry in the same cycle as a CSR write that would rewrite the stack. The bench raises both strobes on one edge, with write data that differs from the stack in every field. It then expects the pushed stack and an unchanged number and marker. A return-from-trap arriving with an update strobe, and an update arriving with a write, are provoked in the same way. In each case the lower event must leave no trace, either in the read data or in the enable pulses.

// File: rtl/intctx_pkg.sv
package intctx_pkg;
   localparam int CTX_W     = 32;
   localparam int FLD_PRIO  = 4;
   localparam int FLD_IRQ   = 9;
   localparam int POS_PPP   = 28;
   localparam int POS_PP    = 24;
   localparam int POS_P     = 16;
   localparam int POS_IDLE  = 15;
   localparam int POS_IRQ   = 4;
   localparam int POS_TSV   = 3;
   localparam int POS_SSV   = 2;
   localparam int POS_CLR   = 1;
   localparam int POS_FLAG  = 0;

   typedef enum logic [2:0] {
      OP_IDLE = 3'd0,
      OP_PUSH = 3'd1,
      OP_POP  = 3'd2,
      OP_DROP = 3'd3,
      OP_UPD  = 3'd4,
      OP_WR   = 3'd5
   } ctx_op_e;
endpackage

// File: rtl/intctx_stack.sv
module intctx_stack
   import intctx_pkg::*;
#(
   parameter int PRIO_W = 4
) (
   input  logic              clk,
   input  logic              rst_n,
   input  ctx_op_e           op,
   input  logic [PRIO_W-1:0] upd_prio,
   input  logic [PRIO_W-1:0] wr_prev2,
   input  logic [PRIO_W-1:0] wr_prev,
   input  logic [PRIO_W:0]   wr_thr,
   input  logic              wr_flag,
   output logic [PRIO_W:0]   thr_q,
   output logic [PRIO_W-1:0] prev_q,
   output logic [PRIO_W-1:0] prev2_q,
   output logic              flag_q
);
   localparam logic [PRIO_W:0]   THR_SAT = {1'b0, {PRIO_W{1'b1}}};
   localparam logic [PRIO_W:0]   ONE     = {{PRIO_W{1'b0}}, 1'b1};

   logic [PRIO_W:0]   cand;
   logic [PRIO_W:0]   prev_ext;
   logic [PRIO_W-1:0] push_val;

   always_comb begin
      cand     = {1'b0, upd_prio} + ONE;
      prev_ext = {1'b0, prev_q};
      push_val = (thr_q > THR_SAT) ? THR_SAT[PRIO_W-1:0] : thr_q[PRIO_W-1:0];
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         thr_q   <= '0;
         prev_q  <= '0;
         prev2_q <= '0;
         flag_q  <= 1'b0;
      end else begin
         unique case (op)
            OP_PUSH: begin
               prev2_q <= prev_q;
               prev_q  <= push_val;
               flag_q  <= 1'b1;
            end
            OP_POP: begin
               if (flag_q) begin
                  thr_q   <= prev_ext;
                  prev_q  <= prev2_q;
                  prev2_q <= '0;
                  flag_q  <= 1'b0;
               end
            end
            OP_DROP: flag_q <= 1'b0;
            OP_UPD:  thr_q  <= (cand > prev_ext) ? cand : prev_ext;
            OP_WR: begin
               thr_q   <= wr_thr;
               prev_q  <= wr_prev;
               prev2_q <= wr_prev2;
               flag_q  <= wr_flag;
            end
            default: ;
         endcase
      end
   end
endmodule

// File: rtl/intctx_ident.sv
module intctx_ident
   import intctx_pkg::*;
#(
   parameter int IRQ_W = 9
) (
   input  logic             clk,
   input  logic             rst_n,
   input  ctx_op_e          op,
   input  logic [IRQ_W-1:0] sel_irq,
   input  logic             sel_none,
   input  logic [IRQ_W-1:0] wr_irq,
   input  logic             wr_idle,
   output logic [IRQ_W-1:0] irq_q,
   output logic             idle_q
);
   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         irq_q  <= '0;
         idle_q <= 1'b1;
      end else if (op == OP_UPD) begin
         irq_q  <= sel_irq;
         idle_q <= sel_none;
      end else if (op == OP_WR) begin
         irq_q  <= wr_irq;
         idle_q <= wr_idle;
      end
   end
endmodule

// File: rtl/intctx_tsave.sv
module intctx_tsave #(
   parameter bit SAVE_EN = 1'b1
) (
   input  logic clk,
   input  logic rst_n,
   input  logic wr_en,
   input  logic wr_clr,
   input  logic wr_tset,
   input  logic wr_sset,
   input  logic mtie_i,
   input  logic msie_i,
   output logic rd_tsv,
   output logic rd_ssv,
   output logic en_clr_o,
   output logic tie_set_o,
   output logic sie_set_o
);
   if (SAVE_EN) begin : g_save
      logic hold_q, tsv_q, ssv_q;

      always_ff @(posedge clk or negedge rst_n) begin
         if (!rst_n) begin
            hold_q <= 1'b0;
            tsv_q  <= 1'b0;
            ssv_q  <= 1'b0;
         end else if (wr_en) begin
            hold_q <= wr_clr;
            if (wr_clr) begin
               tsv_q <= mtie_i;
               ssv_q <= msie_i;
            end
         end
      end

      always_comb begin
         rd_tsv    = hold_q & tsv_q;
         rd_ssv    = hold_q & ssv_q;
         en_clr_o  = wr_en & wr_clr;
         tie_set_o = wr_en & ~wr_clr & wr_tset;
         sie_set_o = wr_en & ~wr_clr & wr_sset;
      end
   end else begin : g_nosave
      logic unused_tsave;
      assign unused_tsave = ^{clk, rst_n, wr_en, wr_clr, wr_tset, wr_sset, mtie_i, msie_i};
      always_comb begin
         rd_tsv    = 1'b0;
         rd_ssv    = 1'b0;
         en_clr_o  = 1'b0;
         tie_set_o = 1'b0;
         sie_set_o = 1'b0;
      end
   end
endmodule

// File: rtl/intctx_reg.sv
module intctx_reg
   import intctx_pkg::*;
#(
   parameter int PRIO_W  = 4,
   parameter int IRQ_W   = 9,
   parameter bit SAVE_EN = 1'b1
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              ext_entry_i,
   input  logic              other_trap_i,
   input  logic              mret_i,
   input  logic              csr_wen_i,
   input  logic [CTX_W-1:0]  csr_wdata_i,
   output logic [CTX_W-1:0]  csr_rdata_o,
   input  logic              upd_i,
   input  logic [PRIO_W-1:0] sel_prio_i,
   input  logic [IRQ_W-1:0]  sel_irq_i,
   input  logic              sel_none_i,
   input  logic              mtie_i,
   input  logic              msie_i,
   output logic              en_clr_o,
   output logic              tie_set_o,
   output logic              sie_set_o,
   output logic [PRIO_W:0]   thr_o,
   output logic [PRIO_W-1:0] thr_prev_o
);
   localparam int THR_W = PRIO_W + 1;

   if (PRIO_W < 1 || PRIO_W > FLD_PRIO) begin : g_bad_prio
      $error("intctx_reg: PRIO_W must lie in 1..4");
   end
   if (IRQ_W < 1 || IRQ_W > FLD_IRQ) begin : g_bad_irq
      $error("intctx_reg: IRQ_W must lie in 1..9");
   end

   ctx_op_e           op;
   logic [THR_W-1:0]  thr_q;
   logic [PRIO_W-1:0] prev_q, prev2_q;
   logic              flag_q;
   logic [IRQ_W-1:0]  irq_q;
   logic              idle_q;
   logic              rd_tsv, rd_ssv;

   // One event per cycle, highest first.
   always_comb begin
      if (ext_entry_i)       op = OP_PUSH;
      else if (mret_i)       op = OP_POP;
      else if (other_trap_i) op = OP_DROP;
      else if (upd_i)        op = OP_UPD;
      else if (csr_wen_i)    op = OP_WR;
      else                   op = OP_IDLE;
   end

   intctx_stack #(.PRIO_W(PRIO_W)) u_stack (
      .clk      (clk),
      .rst_n    (rst_n),
      .op       (op),
      .upd_prio (sel_prio_i),
      .wr_prev2 (csr_wdata_i[POS_PPP +: PRIO_W]),
      .wr_prev  (csr_wdata_i[POS_PP +: PRIO_W]),
      .wr_thr   (csr_wdata_i[POS_P +: THR_W]),
      .wr_flag  (csr_wdata_i[POS_FLAG]),
      .thr_q    (thr_q),
      .prev_q   (prev_q),
      .prev2_q  (prev2_q),
      .flag_q   (flag_q)
   );

   intctx_ident #(.IRQ_W(IRQ_W)) u_ident (
      .clk      (clk),
      .rst_n    (rst_n),
      .op       (op),
      .sel_irq  (sel_irq_i),
      .sel_none (sel_none_i),
      .wr_irq   (csr_wdata_i[POS_IRQ +: IRQ_W]),
      .wr_idle  (csr_wdata_i[POS_IDLE]),
      .irq_q    (irq_q),
      .idle_q   (idle_q)
   );

   intctx_tsave #(.SAVE_EN(SAVE_EN)) u_tsave (
      .clk       (clk),
      .rst_n     (rst_n),
      .wr_en     (op == OP_WR),
      .wr_clr    (csr_wdata_i[POS_CLR]),
      .wr_tset   (csr_wdata_i[POS_TSV]),
      .wr_sset   (csr_wdata_i[POS_SSV]),
      .mtie_i    (mtie_i),
      .msie_i    (msie_i),
      .rd_tsv    (rd_tsv),
      .rd_ssv    (rd_ssv),
      .en_clr_o  (en_clr_o),
      .tie_set_o (tie_set_o),
      .sie_set_o (sie_set_o)
   );

   always_comb begin
      csr_rdata_o                         = '0;
      csr_rdata_o[POS_PPP +: PRIO_W]      = prev2_q;
      csr_rdata_o[POS_PP +: PRIO_W]       = prev_q;
      csr_rdata_o[POS_P +: THR_W]         = thr_q;
      csr_rdata_o[POS_IDLE]               = idle_q;
      csr_rdata_o[POS_IRQ +: IRQ_W]       = irq_q;
      csr_rdata_o[POS_TSV]                = rd_tsv;
      csr_rdata_o[POS_SSV]                = rd_ssv;
      csr_rdata_o[POS_FLAG]               = flag_q;
      thr_o                               = thr_q;
      thr_prev_o                          = prev_q;
   end
endmodule

// File: rtl/intctx_chk.sv
module intctx_chk
   import intctx_pkg::*;
#(
   parameter int PRIO_W = 4
) (
   input logic              clk,
   input logic              rst_n,
   input logic              ext_entry_i,
   input logic              other_trap_i,
   input logic              mret_i,
   input logic              upd_i,
   input logic [PRIO_W-1:0] sel_prio_i,
   input logic [CTX_W-1:0]  csr_rdata_o,
   input logic              en_clr_o,
   input logic              tie_set_o,
   input logic              sie_set_o,
   input logic [PRIO_W:0]   thr_o,
   input logic [PRIO_W-1:0] thr_prev_o
);
   localparam logic [CTX_W-1:0] RSV_MASK = 32'h00E0_6002;
   localparam logic [PRIO_W:0]  SAT      = {1'b0, {PRIO_W{1'b1}}};

   // R1: reserved bits never read as one
   p_rsv_zero_r1: assert property (@(posedge clk) disable iff (!rst_n)
      (csr_rdata_o & RSV_MASK) == '0);

   // R2, R12: entry pushes the (saturated) top threshold
   p_push_r2: assert property (@(posedge clk) disable iff (!rst_n)
      ext_entry_i |=> csr_rdata_o[POS_FLAG] &&
         ({1'b0, thr_prev_o} == (($past(thr_o) > SAT) ? SAT : $past(thr_o))));

   // R3: armed return pops the stack
   p_pop_r3: assert property (@(posedge clk) disable iff (!rst_n)
      (mret_i && !ext_entry_i && csr_rdata_o[POS_FLAG]) |=>
         !csr_rdata_o[POS_FLAG] && (thr_o == {1'b0, $past(thr_prev_o)}));

   // R5: other trap disarms the return flag
   p_drop_r5: assert property (@(posedge clk) disable iff (!rst_n)
      (other_trap_i && !ext_entry_i && !mret_i) |=> !csr_rdata_o[POS_FLAG]);

   // R6: update never lowers the threshold below either bound
   p_upd_r6: assert property (@(posedge clk) disable iff (!rst_n)
      (upd_i && !ext_entry_i && !mret_i && !other_trap_i) |=>
         (thr_o >= {1'b0, $past(thr_prev_o)}) && (thr_o > {1'b0, $past(sel_prio_i)}));

   // R9: clear and set pulses never coincide
   p_pulse_r9: assert property (@(posedge clk) disable iff (!rst_n)
      en_clr_o |-> !tie_set_o && !sie_set_o);
endmodule

bind intctx_reg intctx_chk #(.PRIO_W(PRIO_W)) u_chk (
   .clk          (clk),
   .rst_n        (rst_n),
   .ext_entry_i  (ext_entry_i),
   .other_trap_i (other_trap_i),
   .mret_i       (mret_i),
   .upd_i        (upd_i),
   .sel_prio_i   (sel_prio_i),
   .csr_rdata_o  (csr_rdata_o),
   .en_clr_o     (en_clr_o),
   .tie_set_o    (tie_set_o),
   .sie_set_o    (sie_set_o),
   .thr_o        (thr_o),
   .thr_prev_o   (thr_prev_o)
);

// File: tb/intctx_reg_tb.sv
module intctx_reg_tb;
   logic        clk = 1'b0;
   logic        rst_n = 1'b0;
   logic        ext_entry_i = 0, other_trap_i = 0, mret_i = 0, csr_wen_i = 0;
   logic [31:0] csr_wdata_i = '0;
   logic [31:0] csr_rdata_o;
   logic        upd_i = 0;
   logic [3:0]  sel_prio_i = '0;
   logic [8:0]  sel_irq_i = '0;
   logic        sel_none_i = 0;
   logic        mtie_i = 0, msie_i = 0;
   logic        en_clr_o, tie_set_o, sie_set_o;
   logic [4:0]  thr_o;
   logic [3:0]  thr_prev_o;

   int n_chk = 0;
   int n_fail = 0;

   typedef struct {
      logic [31:0] rd;
      logic [4:0]  thr;
      logic [3:0]  prev;
      string       tag;
   } exp_t;
   exp_t sb_q[$];
   event ev_chk;

   // bench model
   logic [3:0] m_ppp = 0, m_pp = 0;
   logic [4:0] m_p = 0;
   logic       m_idle = 1, m_flag = 0, m_hold = 0, m_tsv = 0, m_ssv = 0;
   logic [8:0] m_irq = 0;

   always #5 clk = ~clk;

   intctx_reg u_dut (
      .clk(clk), .rst_n(rst_n), .ext_entry_i(ext_entry_i), .other_trap_i(other_trap_i),
      .mret_i(mret_i), .csr_wen_i(csr_wen_i), .csr_wdata_i(csr_wdata_i),
      .csr_rdata_o(csr_rdata_o), .upd_i(upd_i), .sel_prio_i(sel_prio_i),
      .sel_irq_i(sel_irq_i), .sel_none_i(sel_none_i), .mtie_i(mtie_i), .msie_i(msie_i),
      .en_clr_o(en_clr_o), .tie_set_o(tie_set_o), .sie_set_o(sie_set_o),
      .thr_o(thr_o), .thr_prev_o(thr_prev_o)
   );

   function automatic logic [31:0] m_rd();
      return {m_ppp, m_pp, 3'b000, m_p, m_idle, 2'b00, m_irq,
              m_hold & m_tsv, m_hold & m_ssv, 1'b0, m_flag};
   endfunction

   function automatic logic [31:0] mk(input logic [3:0] ppp, input logic [3:0] pp,
                                      input logic [4:0] p, input logic idle,
                                      input logic [8:0] irq, input logic [3:0] low);
      return {ppp, pp, 3'b000, p, idle, 2'b00, irq, low};
   endfunction

   task automatic push_exp(input string tag);
      exp_t e;
      e.rd = m_rd(); e.thr = m_p; e.prev = m_pp; e.tag = tag;
      sb_q.push_back(e);
      -> ev_chk;
   endtask

   // monitor: compares design outputs against queued expectations
   initial begin
      forever begin
         @(ev_chk);
         while (sb_q.size() > 0) begin
            exp_t e;
            e = sb_q.pop_front();
            n_chk++;
            if (csr_rdata_o !== e.rd) begin
               n_fail++;
               $display("FAIL %s rdata actual=%h expected=%h", e.tag, csr_rdata_o, e.rd);
            end
            n_chk++; // R11
            if (thr_o !== e.thr || thr_prev_o !== e.prev) begin
               n_fail++;
               $display("FAIL R11 (%s) thr actual=%0d/%0d expected=%0d/%0d",
                        e.tag, thr_o, thr_prev_o, e.thr, e.prev);
            end
         end
      end
   end

   task automatic step(input logic e, input logic m, input logic t, input logic u,
                       input logic [3:0] pr, input logic [8:0] iq, input logic nn,
                       input logic w, input logic [31:0] wd, input string tag);
      logic is_wr;
      logic x_clr, x_ts, x_ss;
      logic [4:0] c;
      @(negedge clk);
      ext_entry_i = e; mret_i = m; other_trap_i = t; upd_i = u;
      sel_prio_i = pr; sel_irq_i = iq; sel_none_i = nn;
      csr_wen_i = w; csr_wdata_i = wd;
      #1;
      is_wr = w && !e && !m && !t && !u;
      x_clr = is_wr && wd[1];
      x_ts  = is_wr && !wd[1] && wd[3];
      x_ss  = is_wr && !wd[1] && wd[2];
      n_chk++; // R8 R9 R10 pulses
      if (en_clr_o !== x_clr || tie_set_o !== x_ts || sie_set_o !== x_ss) begin
         n_fail++;
         $display("FAIL R9 (%s) pulses actual=%b%b%b expected=%b%b%b", tag,
                  en_clr_o, tie_set_o, sie_set_o, x_clr, x_ts, x_ss);
      end
      // model next state
      if (e) begin
         m_ppp = m_pp;
         m_pp = (m_p > 5'd15) ? 4'd15 : m_p[3:0];
         m_flag = 1'b1;
      end else if (m) begin
         if (m_flag) begin
            m_p = {1'b0, m_pp}; m_pp = m_ppp; m_ppp = 0; m_flag = 0;
         end
      end else if (t) begin
         m_flag = 0;
      end else if (u) begin
         c = {1'b0, pr} + 5'd1;
         m_p = (c > {1'b0, m_pp}) ? c : {1'b0, m_pp};
         m_irq = iq; m_idle = nn;
      end else if (w) begin
         m_ppp = wd[31:28]; m_pp = wd[27:24]; m_p = wd[20:16];
         m_idle = wd[15]; m_irq = wd[12:4]; m_flag = wd[0];
         m_hold = wd[1];
         if (wd[1]) begin m_tsv = mtie_i; m_ssv = msie_i; end
      end
      @(posedge clk);
      #2;
      ext_entry_i = 0; mret_i = 0; other_trap_i = 0; upd_i = 0; csr_wen_i = 0;
      push_exp(tag);
   endtask

   initial begin
      repeat (200000) @(posedge clk);
      n_fail++;
      $display("FAIL watchdog expired");
      $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
      $finish;
   end

   initial begin
      repeat (3) @(posedge clk);
      #2;
      push_exp("R1 reset");          // expects 0x0000_8000
      @(negedge clk); rst_n = 1'b1;
      // R7 plain write
      step(0,0,0,0, 0, 0, 0, 1, mk(4'd3, 4'd5, 5'd7, 1'b0, 9'h1A5, 4'b0000), "R7 write");
      // R6 update bounded by second threshold
      step(0,0,0,1, 4'd2, 9'h011, 0, 0, '0, "R6 update low prio");
      step(0,0,0,1, 4'd9, 9'h0F0, 0, 0, '0, "R6 update high prio");
      step(0,0,0,1, 4'd15, 9'h1FF, 1, 0, '0, "R6 update max prio");
      // R2 push and R12 saturation (top = 16)
      step(1,0,0,0, 0, 0, 0, 0, '0, "R2 R12 entry push sat");
      // R3 armed pop
      step(0,1,0,0, 0, 0, 0, 0, '0, "R3 pop");
      // R4 unarmed return
      step(0,1,0,0, 0, 0, 0, 0, '0, "R4 mret unarmed");
      // R5 other trap disarms, then return does nothing
      step(1,0,0,0, 0, 0, 0, 0, '0, "R2 entry push");
      step(0,0,1,0, 0, 0, 0, 0, '0, "R5 other trap");
      step(0,1,0,0, 0, 0, 0, 0, '0, "R4 mret after trap");
      // R10 collisions
      step(1,0,0,0, 0, 0, 0, 1, mk(4'hA, 4'hB, 5'h1C, 1'b1, 9'h155, 4'b1001), "R10 entry+write");
      step(0,1,0,1, 4'd3, 9'h003, 0, 0, '0, "R10 mret+update");
      step(0,0,0,1, 4'd1, 9'h042, 0, 1, mk(4'h1, 4'h2, 5'h3, 1'b1, 9'h077, 4'b1110), "R10 update+write");
      // R8 clear-and-save
      mtie_i = 1; msie_i = 0;
      step(0,0,0,0, 0, 0, 0, 1, mk(4'd0, 4'd2, 5'd4, 1'b0, 9'h010, 4'b0010), "R8 clear save");
      mtie_i = 0; msie_i = 1;
      step(0,0,0,0, 0, 0, 0, 1, mk(4'd0, 4'd2, 5'd4, 1'b0, 9'h010, 4'b1011), "R9 clear suppresses set");
      // R9 restore enables, hold ends
      step(0,0,0,0, 0, 0, 0, 1, mk(4'd0, 4'd2, 5'd4, 1'b0, 9'h010, 4'b1100), "R9 set pulses");
      step(0,0,0,0, 0, 0, 0, 0, '0, "R8 idle readback");
      @(negedge clk);
      $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
      $finish;
   end
endmodule